// File: doc/BRIEF.md
# Match Event Timer with Cross-Domain Clear

This block is a programmable up-counter for a processor. Software reaches it through a small register window on the bus clock. The counter itself runs on a separate, slower timer clock. Software loads a compare value and chooses a prescale ratio. It can then start and stop the count, read the current count at any time, and restart it from zero with a clear command. A one-clock pulse on the interrupt output marks each time the count steps onto the compare value. An optional auto-zero mode turns the timer into a periodic tick source.

Every path between the two clock domains goes through a synchroniser. Each clear command is carried to the timer clock as a toggle, and an acknowledge toggle comes back the same way. While that round trip is in flight, a status bit reads as 1. Before software starts a new interval it issues a clear, polls the status bit until it reads 0, loads the compare value and then sets the run bit. The count comes back to the bus clock in Gray code. The compare value, the prescale code and the control bits are expected to change only while the timer is stopped.

Top module: `mt_match_timer`

## Requirements
- R1: After both resets, every register reads 0, the interrupt output is low and the counter is stopped.
- R2: A read at offset 0x00 returns the compare value (its low CNT_W bits). A read at 0x08 returns the run bit in bit 0 and the auto-zero bit in bit 1. A read at 0x10 returns the prescale code in its low DIV_W bits. All unused bits read 0.
- R3: A write of any value to offset 0x0C zeroes the count and the prescale phase. From the bus cycle after the write, bit 10 of a read at 0x0C is 1. It returns to 0 once the acknowledge arrives back. A clear write made while that bit is 1 is ignored.
- R4: While the run bit is 0, the count does not change.
- R5: Prescale code c makes the count advance once every c+1 timer clocks. For example, code 3 gives one step per four timer clocks. Two reads at offset 0x04 taken K timer clocks apart, where K is a multiple of c+1, differ by exactly K/(c+1).
- R6: While running, each step of the count onto the compare value produces a one-timer-clock high pulse on `tmr_irq`.
- R7: With auto-zero set, the step after the count equals the compare value takes it to 0. This gives an interrupt every (compare+1) steps, and the count never exceeds the compare value.
- R8: The count runs modulo 2^CNT_W and continues from all-ones to 0, so the compare value is hit again on every lap.
- R9: After the run bit is cleared and has crossed into the timer clock, no further interrupt pulses occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus clock domain |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| tmr_clk | input | 1 | Timer clock |
| tmr_rst_n | input | 1 | Synchronous active-low reset, timer clock domain |
| tmr_irq | output | 1 | One-timer-clock pulse when the count steps onto the compare value |

## Verification
The bench builds the block with CNT_W = 12 and DIV_W = 2. At that width a full lap of the counter takes 4096 timer clocks, so the wrap and the second compare hit on the next lap fall inside a short run. All four prescale codes stay available. The timer clock is exactly three bus clocks long and is offset from the bus clock. Because of this, two count reads a fixed number of timer clocks apart see an exact step difference. The bench therefore checks the prescale ratio for an exact count and does not need a tolerance window.

// File: rtl/mt_pkg.sv
// Package: shared register offsets and bit positions for the match timer.
// Assumes a byte-addressed register window of 32-bit registers.
package mt_pkg;
    localparam int ADDR_W        = 5;
    localparam logic [ADDR_W-1:0] OFS_MATCH = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CLEAR = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_DIV   = 5'h10;
    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_AZ_BIT   = 1;
    localparam int PEND_BIT      = 10;
endpackage

// File: rtl/mt_sync.sv
// Module: multi-stage flop synchroniser for a vector of signals.
// Assumes each bit is either a single toggle, or a Gray-coded or
// quasi-static vector, so bit skew across the vector is harmless.
module mt_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    // Shift the input through the synchroniser stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/mt_regs.sv
// Module: bus-clock register file. Decodes writes, builds read data,
// issues clear toggles and turns the synchronised Gray count back to
// binary. Assumes match, divider and control are written while stopped.
module mt_regs
    import mt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int DIV_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [CNT_W-1:0]  match_o,
    output logic [DIV_W-1:0]  div_o,
    output logic              run_o,
    output logic              az_o,
    output logic              clr_tog_o,
    input  logic              ack_tog_i,
    input  logic [CNT_W-1:0]  cnt_gray_i
);
    logic [CNT_W-1:0] match_q;
    logic [DIV_W-1:0] div_q;
    logic             run_q, az_q, clr_tog_q;
    logic             wr_en, clr_wr, pending;
    logic [CNT_W-1:0] cnt_bin;
    logic [31:0]      unused_wdata_bits;

    assign wr_en   = sel && wr;
    assign clr_wr  = wr_en && (addr == OFS_CLEAR);
    assign pending = clr_tog_q ^ ack_tog_i;
    assign unused_wdata_bits = wdata;

    // Register writes; a clear while one is in flight is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q   <= '0;
            div_q     <= '0;
            run_q     <= 1'b0;
            az_q      <= 1'b0;
            clr_tog_q <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                OFS_MATCH: match_q <= wdata[CNT_W-1:0];
                OFS_CTRL: begin
                    run_q <= wdata[CTRL_RUN_BIT];
                    az_q  <= wdata[CTRL_AZ_BIT];
                end
                OFS_DIV:   div_q <= wdata[DIV_W-1:0];
                OFS_CLEAR: if (!pending) clr_tog_q <= ~clr_tog_q;
                default: ;
            endcase
        end
    end

    // Gray to binary conversion of the synchronised count.
    always_comb begin
        cnt_bin[CNT_W-1] = cnt_gray_i[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) cnt_bin[i] = cnt_bin[i+1] ^ cnt_gray_i[i];
    end

    // Read data multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_MATCH: rdata[CNT_W-1:0] = match_q;
            OFS_COUNT: rdata[CNT_W-1:0] = cnt_bin;
            OFS_CTRL: begin
                rdata[CTRL_RUN_BIT] = run_q;
                rdata[CTRL_AZ_BIT]  = az_q;
            end
            OFS_CLEAR: rdata[PEND_BIT] = pending;
            OFS_DIV:   rdata[DIV_W-1:0] = div_q;
            default: ;
        endcase
    end

    assign match_o   = match_q;
    assign div_o     = div_q;
    assign run_o     = run_q;
    assign az_o      = az_q;
    assign clr_tog_o = clr_tog_q;

    // R3: an accepted clear write shows as pending on the next cycle.
    a_r3_pending_set: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !pending) |=> pending);

    // R3: a clear write while pending leaves the request in flight.
    a_r3_pending_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && pending) |=> $stable(clr_tog_q));
endmodule

// File: rtl/mt_core.sv
// Module: timer-clock counter. Holds the prescaler, the counter, the
// compare and the interrupt pulse, and detects clear toggles.
// Assumes all inputs are already synchronised to tmr_clk.
module mt_core #(
    parameter int CNT_W = 32,
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             az,
    input  logic [CNT_W-1:0] match,
    input  logic [DIV_W-1:0] div,
    input  logic             clr_tog,
    output logic             ack_tog,
    output logic [CNT_W-1:0] cnt_gray,
    output logic             irq
);
    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    logic [DIV_W-1:0] pre_q, pre_nxt;
    logic             seen_q, clr_evt, step, hit, irq_q;
    logic [CNT_W-1:0] gray_q;

    assign clr_evt = clr_tog ^ seen_q;
    assign step    = run && (pre_q >= div);

    // Next-state logic for prescaler, counter and compare.
    always_comb begin
        cnt_nxt = cnt_q;
        pre_nxt = pre_q;
        hit     = 1'b0;
        if (clr_evt) begin
            cnt_nxt = '0;
            pre_nxt = '0;
        end else if (step) begin
            pre_nxt = '0;
            if (az && (cnt_q == match)) cnt_nxt = '0;
            else                        cnt_nxt = cnt_q + 1'b1;
            hit = (cnt_nxt == match);
        end else if (run) begin
            pre_nxt = pre_q + 1'b1;
        end
    end

    // Timer-domain state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pre_q  <= '0;
            seen_q <= 1'b0;
            irq_q  <= 1'b0;
            gray_q <= '0;
        end else begin
            cnt_q  <= cnt_nxt;
            pre_q  <= pre_nxt;
            seen_q <= clr_tog;
            irq_q  <= hit;
            gray_q <= cnt_nxt ^ (cnt_nxt >> 1);
        end
    end

    assign ack_tog  = seen_q;
    assign cnt_gray = gray_q;
    assign irq      = irq_q;

    // R3: a detected clear leaves the count at zero.
    a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_evt |=> (cnt_q == '0));

    // R4: stopped and no clear means the count holds.
    a_r4_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr_evt) |=> $stable(cnt_q));

    // R6: a pulse only appears with the count on the compare value.
    a_r6_irq_at_match: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (cnt_q == $past(match)));

    // R7: auto-zero returns the count to zero after the compare.
    a_r7_autozero: assert property (@(posedge clk) disable iff (!rst_n)
        (step && az && !clr_evt && cnt_q == match) |=> (cnt_q == '0));

    // R8: all-ones rolls over to zero without auto-zero.
    a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !az && !clr_evt && (&cnt_q)) |=> (cnt_q == '0));

    // R9: no pulse follows a stopped cycle.
    a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !irq_q);
endmodule

// File: rtl/mt_match_timer.sv
// Module: top of the match timer. Bus-side registers, synchronisers in
// both directions and the timer-clock counter core.
// Assumes bus and timer clocks are asynchronous to each other.
module mt_match_timer
    import mt_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int DIV_W   = 2,
    parameter int SYNC_ST = 2
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tmr_clk,
    input  logic              tmr_rst_n,
    output logic              tmr_irq
);
    localparam int FWD_W = CNT_W + DIV_W + 3;
    localparam int BCK_W = CNT_W + 1;

    logic [CNT_W-1:0] match_b, match_t, gray_t, gray_b;
    logic [DIV_W-1:0] div_b, div_t;
    logic             run_b, az_b, clr_b, run_t, az_t, clr_t, ack_t, ack_b;

    mt_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
        .clk(bus_clk), .rst_n(bus_rst_n), .sel(bus_sel), .wr(bus_wr),
        .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
        .match_o(match_b), .div_o(div_b), .run_o(run_b), .az_o(az_b),
        .clr_tog_o(clr_b), .ack_tog_i(ack_b), .cnt_gray_i(gray_b)
    );

    mt_sync #(.W(FWD_W), .STAGES(SYNC_ST)) u_sync_fwd (
        .clk(tmr_clk), .rst_n(tmr_rst_n),
        .d({match_b, div_b, run_b, az_b, clr_b}),
        .q({match_t, div_t, run_t, az_t, clr_t})
    );

    mt_core #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_core (
        .clk(tmr_clk), .rst_n(tmr_rst_n), .run(run_t), .az(az_t),
        .match(match_t), .div(div_t), .clr_tog(clr_t),
        .ack_tog(ack_t), .cnt_gray(gray_t), .irq(tmr_irq)
    );

    mt_sync #(.W(BCK_W), .STAGES(SYNC_ST)) u_sync_back (
        .clk(bus_clk), .rst_n(bus_rst_n),
        .d({gray_t, ack_t}),
        .q({gray_b, ack_b})
    );
endmodule

// File: tb/mt_match_timer_test.sv
module mt_match_timer_test;
    localparam int CW   = 12;
    localparam int MASK = (1 << CW) - 1;

    logic        bus_clk = 0, tmr_clk = 0;
    logic        bus_rst_n = 0, tmr_rst_n = 0;
    logic        bus_sel = 0, bus_wr = 0;
    logic [4:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        tmr_irq;

    int total = 0, fails = 0, edges = 0;
    logic irq_prev = 0;
    // behavioural shadow of writable registers
    int sh_match = 0, sh_ctrl = 0, sh_div = 0;

    mt_match_timer #(.CNT_W(CW), .DIV_W(2)) uut (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tmr_clk(tmr_clk), .tmr_rst_n(tmr_rst_n),
        .tmr_irq(tmr_irq)
    );

    always #10 bus_clk = ~bus_clk;
    initial begin
        #5;
        forever #30 tmr_clk = ~tmr_clk;
    end

    // count rising edges of the interrupt, sampled mid-cycle
    always @(negedge tmr_clk) begin
        if (tmr_irq && !irq_prev) edges++;
        irq_prev = tmr_irq;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input int d);
        @(negedge bus_clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge bus_clk);
        bus_sel = 0; bus_wr = 0;
        if (a == 5'h00) sh_match = d & MASK;
        if (a == 5'h08) sh_ctrl = d & 3;
        if (a == 5'h10) sh_div = d & 3;
    endtask

    task automatic rd(input logic [4:0] a, output int d);
        @(negedge bus_clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic wait_tmr(input int n);
        repeat (n * 3) @(negedge bus_clk);
    endtask

    task automatic clear_and_wait();
        int v;
        wr(5'h0C, 0);
        for (int i = 0; i < 60; i++) begin
            rd(5'h0C, v);
            if (!v[10]) break;
        end
        check(v[10] == 0, "R3 pending drops", v[10], 0);
        wait_tmr(4);
    endtask

    task automatic rate(input int code, input int k);
        int a, b, d;
        wr(5'h08, 0);
        wr(5'h10, code);
        wr(5'h08, 1);
        wait_tmr(10);
        rd(5'h04, a);
        repeat (3 * k - 1) @(negedge bus_clk);
        rd(5'h04, b);
        d = (b - a) & MASK;
        check(d == k / (code + 1), $sformatf("R5 step count code %0d", code), d, k / (code + 1));
    endtask

    initial begin
        int v, a, b, e0;
        repeat (4) @(negedge bus_clk);
        bus_rst_n = 1; tmr_rst_n = 1;
        wait_tmr(2);

        // R1 reset state
        for (int i = 0; i < 5; i++) begin
            rd(5'(i * 4), v);
            check(v == 0, "R1 register after reset", v, 0);
        end
        check(tmr_irq == 0, "R1 irq after reset", tmr_irq, 0);
        wait_tmr(20);
        rd(5'h04, v);
        check(v == 0, "R1 counter stopped", v, 0);

        // R2 readback against shadow
        wr(5'h00, 32'h1234_5678);
        wr(5'h10, 32'hFFFF_FFFE);
        wr(5'h08, 32'hFFFF_FFFE);
        rd(5'h00, v); check(v == sh_match, "R2 match readback", v, sh_match);
        rd(5'h10, v); check(v == sh_div, "R2 divider readback", v, sh_div);
        rd(5'h08, v); check(v == sh_ctrl, "R2 control readback", v, sh_ctrl);
        wr(5'h08, 0);
        wr(5'h10, 0);

        // R5 prescale ratios (also runs the count up)
        rate(0, 40);
        rate(1, 40);
        rate(2, 42);
        rate(3, 40);

        // R4 frozen count
        wr(5'h08, 0);
        wait_tmr(10);
        rd(5'h04, a);
        wait_tmr(30);
        rd(5'h04, b);
        check(a == b, "R4 count frozen", b, a);
        check(a != 0, "R4 count nonzero before clear", a, 1);

        // R3 clear handshake and ignored second clear
        wr(5'h0C, 32'h5A5A);
        rd(5'h0C, v);
        check(v == (1 << 10), "R3 pending set", v, 1 << 10);
        wr(5'h0C, 0);
        rd(5'h0C, v);
        check(v[10] == 1, "R3 second clear ignored", v[10], 1);
        for (int i = 0; i < 60; i++) begin
            rd(5'h0C, v);
            if (!v[10]) break;
        end
        check(v[10] == 0, "R3 pending drops", v[10], 0);
        wait_tmr(4);
        rd(5'h04, v);
        check(v == 0, "R3 count zeroed", v, 0);

        // R6 single match pulse
        wr(5'h10, 0);
        wr(5'h00, 50);
        e0 = edges;
        wr(5'h08, 1);
        wait_tmr(80);
        check(edges - e0 == 1, "R6 one pulse at match", edges - e0, 1);

        // R8 wrap: second hit on the next lap
        wr(5'h08, 0);
        clear_and_wait();
        wr(5'h00, 5);
        e0 = edges;
        wr(5'h08, 1);
        wait_tmr(4200);
        check(edges - e0 == 2, "R8 hit again after wrap", edges - e0, 2);
        rd(5'h04, v);
        check(v > 50 && v < 200, "R8 count restarted from zero", v, 100);

        // R7 auto-zero periodic mode
        wr(5'h08, 0);
        clear_and_wait();
        wr(5'h00, 9);
        e0 = edges;
        wr(5'h08, 3);
        for (int i = 0; i < 20; i++) begin
            wait_tmr(10);
            rd(5'h04, v);
            check(v <= 9, "R7 count bounded by compare", v, 9);
        end
        check(edges - e0 >= 18 && edges - e0 <= 21, "R7 pulse rate", edges - e0, 20);

        // R9 stopping suppresses pulses
        wr(5'h08, 2);
        wait_tmr(10);
        e0 = edges;
        wait_tmr(100);
        check(edges == e0, "R9 no pulse when stopped", edges - e0, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge bus_clk);
        total++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule